// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sits in the always-on clock domain of a small microcontroller and decides when the oscillator and the CPU clock may run. Software chooses between two power-saving states by writing a control register. In stop state the oscillator is switched off, which also stops the CPU clock. In halt state only the CPU clock is gated, and the oscillator keeps running. The block drives an oscillator-enable and a CPU-clock-enable output. The clock-gating cells and the oscillator are outside it.

There are four wake inputs: three timer events and a port interrupt. A release-enable register decides which of them may end halt state. When one of them does, a sticky status register records the cause, and software clears it bit by bit with a write-one-to-clear register. Stop state has a narrower wake set: only the port interrupt ends it, and it ends it whether or not the port is enabled. Both states also end on reset. That reset is asynchronous, active low and released synchronously. The register interface is a single-cycle synchronous bus. Reads are combinational.

Top module: `lpwr_wake_top`

## Requirements
- R1: After reset every register reads 0x00, `osc_en` is 1 and `cpu_clk_en` is 1.
- R2: Register map and fields.
  - Mode register at 0xC5: bit 2 is stop and bit 1 is halt.
  - Release-enable register at 0xC6: bit 1 is timer 0, bit 2 is port, bit 3 is timer 1 and bit 4 is timer 2.
  - Status register at 0xC7 is read-only and uses the same bit layout as the release-enable register.
  - Clear register at 0xC8 is write-only and reads 0.
  - Unused bits and unmapped addresses read 0, and writes to them have no effect.
- R3: Writing halt=1 leaves `osc_en` at 1. `cpu_clk_en` falls one cycle after the edge that sets the bit.
- R4: Writing stop=1 drops `osc_en` on the same edge that sets the bit. `cpu_clk_en` falls one cycle later.
- R5: In halt state (halt=1, stop=0), an event on an enabled source clears the halt bit on the next edge. `cpu_clk_en` rises one cycle after that.
- R6: In halt state, an event on a source whose enable bit is 0 leaves halt set.
- R7: In stop state, a port event clears both mode bits on the next edge and raises `osc_en`, whatever the enables hold.
- R8: In stop state, timer events do not clear the stop bit.
- R9: A status bit sets only when its source releases halt state. Events outside halt state, including events in stop state, leave status unchanged. Simultaneous enabled events set all of their bits.
- R10: Writing 1 to a bit of the clear register clears that status bit and leaves the others. If a clear and a new set land in the same cycle, the set wins.
- R11: If a wake condition and a bus write to the mode register land in the same cycle, the wake wins and the mode bits end at 0.
- R12: Asserting reset in stop or halt state raises `osc_en` and `cpu_clk_en` at once, without a clock edge, and clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset (hardware or power-on) |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| evt_tmr0 | input | 1 | Timer 0 event |
| evt_tmr1 | input | 1 | Timer 1 event |
| evt_tmr2 | input | 1 | Timer 2 event |
| evt_port | input | 1 | Port interrupt event |
| osc_en | output | 1 | Oscillator enable, low in stop state |
| cpu_clk_en | output | 1 | CPU clock enable, registered |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is a wake event and a software write. A wake event lands on the same edge as a write to the mode register, and the bench checks that the mode bits read 0 afterwards.

The second pair is a new status set and a clear of the same bit. A halt release sets a status bit on the edge where the clear register writes 1 to that bit, and also to another bit. The bench expects the new cause to survive and the other bit to be gone.

Both collisions are forced by holding the write strobe and the event together across a single edge. The halt and stop wake paths are swept over every source and, for halt, every enable mask.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_SRC = 4;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 8'hC5;
  localparam logic [ADDR_W-1:0] ADDR_REL_EN = 8'hC6;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 8'hC7;
  localparam logic [ADDR_W-1:0] ADDR_CLR    = 8'hC8;

  localparam int unsigned BIT_HALT = 1;
  localparam int unsigned BIT_STOP = 2;
  localparam int unsigned SRC_LSB  = 1;
  localparam int unsigned SRC_PORT = 1;

  localparam logic [DATA_W-1:0] MODE_MASK = (DATA_W'(1) << BIT_HALT) | (DATA_W'(1) << BIT_STOP);
  localparam logic [DATA_W-1:0] SRC_MASK  = DATA_W'(((1 << NUM_SRC) - 1) << SRC_LSB);

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef struct packed {
    logic stop;
    logic halt;
  } mode_bits_t;
endpackage

// File: rtl/lpw_rst_sync.sv
module lpw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpw_wake_decode.sv
module lpw_wake_decode
  import lpw_pkg::*;
(
  input  mode_bits_t mode_q,
  input  src_vec_t   rel_en,
  input  src_vec_t   evt,
  output src_vec_t   halt_hits,
  output logic       halt_wake,
  output logic       stop_wake
);
  logic halt_only;

  always_comb begin
    halt_only = mode_q.halt & ~mode_q.stop;
    halt_hits = halt_only ? (rel_en & evt) : '0;
    halt_wake = |halt_hits;
    stop_wake = mode_q.stop & evt[SRC_PORT];
  end
endmodule

// File: rtl/lpw_mode_ctrl.sv
module lpw_mode_ctrl
  import lpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  mode_bits_t mode_wdata,
  input  logic       halt_wake,
  input  logic       stop_wake,
  output mode_bits_t mode_q,
  output logic       osc_en,
  output logic       cpu_clk_en
);
  mode_bits_t mode_d;
  logic       mode_upd;
  logic       wake_any;
  logic       cpu_en_d;
  logic       cpu_en_q;

  always_comb begin
    wake_any = halt_wake | stop_wake;
    mode_upd = mode_wr | wake_any;
    mode_d   = mode_q;
    if (mode_wr)  mode_d = mode_wdata;
    if (wake_any) mode_d = '0;
    cpu_en_d = ~(mode_q.halt | mode_q.stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cpu_en_q <= 1'b1;
    end else begin
      if (mode_upd) mode_q <= mode_d;
      cpu_en_q <= cpu_en_d;
    end
  end

  assign osc_en     = ~mode_q.stop;
  assign cpu_clk_en = cpu_en_q;
endmodule

// File: rtl/lpw_status.sv
module lpw_status
  import lpw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     clr_wr,
  input  src_vec_t clr_mask,
  output src_vec_t status_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = set_vec[i] | (clr_wr & clr_mask[i]);
      bit_d  = set_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_q[i] <= 1'b0;
      else if (bit_en) status_q[i] <= bit_d;
    end
  end
endmodule

// File: rtl/lpwr_wake_top.sv
module lpwr_wake_top
  import lpw_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_tmr0,
  input  logic              evt_tmr1,
  input  logic              evt_tmr2,
  input  logic              evt_port,
  output logic              osc_en,
  output logic              cpu_clk_en
);
  logic              rst_core_n;
  logic              wr_mode;
  logic              wr_rel;
  logic              wr_clr;
  mode_bits_t        mode_wdata;
  mode_bits_t        mode_q;
  logic              stop_q;
  logic              halt_q;
  logic [DATA_W-1:0] rel_word_d;
  logic [DATA_W-1:0] rel_word_q;
  src_vec_t          rel_en;
  src_vec_t          evt_vec;
  src_vec_t          halt_hits;
  src_vec_t          status_q;
  src_vec_t          clr_mask;
  logic              halt_wake;
  logic              stop_wake;

  lpw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    wr_mode         = bus_we && (bus_addr == ADDR_MODE);
    wr_rel          = bus_we && (bus_addr == ADDR_REL_EN);
    wr_clr          = bus_we && (bus_addr == ADDR_CLR);
    mode_wdata.stop = bus_wdata[BIT_STOP];
    mode_wdata.halt = bus_wdata[BIT_HALT];
    rel_word_d      = bus_wdata & SRC_MASK;
    clr_mask        = bus_wdata[SRC_LSB +: NUM_SRC];
    evt_vec         = {evt_tmr2, evt_tmr1, evt_port, evt_tmr0};
    rel_en          = rel_word_q[SRC_LSB +: NUM_SRC];
    stop_q          = mode_q.stop;
    halt_q          = mode_q.halt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rel_word_q <= '0;
    else if (wr_rel)  rel_word_q <= rel_word_d;
  end

  lpw_wake_decode u_dec (
    .mode_q    (mode_q),
    .rel_en    (rel_en),
    .evt       (evt_vec),
    .halt_hits (halt_hits),
    .halt_wake (halt_wake),
    .stop_wake (stop_wake)
  );

  lpw_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .mode_wr    (wr_mode),
    .mode_wdata (mode_wdata),
    .halt_wake  (halt_wake),
    .stop_wake  (stop_wake),
    .mode_q     (mode_q),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en)
  );

  lpw_status u_stat (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .set_vec  (halt_hits),
    .clr_wr   (wr_clr),
    .clr_mask (clr_mask),
    .status_q (status_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_MODE: begin
        bus_rdata[BIT_STOP] = stop_q;
        bus_rdata[BIT_HALT] = halt_q;
      end
      ADDR_REL_EN: bus_rdata = rel_word_q;
      ADDR_STAT:   bus_rdata[SRC_LSB +: NUM_SRC] = status_q;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpw_chk.sv
module lpw_chk
  import lpw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input src_vec_t          evt,
  input logic              stop_q,
  input logic              halt_q,
  input src_vec_t          rel_en,
  input src_vec_t          status_q,
  input logic              osc_en,
  input logic              cpu_clk_en
);
  logic mode_wr;
  logic clr_wr;
  logic in_halt;

  assign mode_wr = bus_we && (bus_addr == ADDR_MODE);
  assign clr_wr  = bus_we && (bus_addr == ADDR_CLR);
  assign in_halt = halt_q && !stop_q;

  AST_HALT_KEEPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    in_halt |-> osc_en); // R3
  AST_LOWPWR_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q || stop_q) |=> !cpu_clk_en); // R4
  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && ((rel_en & evt) != '0)) |=> (!halt_q ##1 cpu_clk_en)); // R5
  AST_HALT_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && ((rel_en & evt) == '0) && !mode_wr) |=> halt_q); // R6
  AST_STOP_PORT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && evt[SRC_PORT]) |=> (!stop_q && !halt_q && osc_en)); // R7
  AST_STOP_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !evt[SRC_PORT] && !mode_wr) |=> stop_q); // R8
  AST_STATUS_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_halt |=> ((status_q & $past(rel_en & evt)) == $past(rel_en & evt))); // R9
  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_halt && !clr_wr) |=> $stable(status_q)); // R10
endmodule

bind lpwr_wake_top lpw_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .evt        (evt_vec),
  .stop_q     (stop_q),
  .halt_q     (halt_q),
  .rel_en     (rel_en),
  .status_q   (status_q),
  .osc_en     (osc_en),
  .cpu_clk_en (cpu_clk_en)
);

// File: tb/lpwr_wake_top_tb_top.sv
`timescale 1ns/1ps
module lpwr_wake_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] evt_drv;
  logic       osc_en;
  logic       cpu_clk_en;
  int         n_cmp;
  int         n_bad;

  lpwr_wake_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_tmr0   (evt_drv[0]),
    .evt_tmr1   (evt_drv[2]),
    .evt_tmr2   (evt_drv[3]),
    .evt_port   (evt_drv[1]),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    cyc();
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; evt_drv = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    rd(8'hC5, v); check("R1 mode", v, 0);
    rd(8'hC6, v); check("R1 rel_en", v, 0);
    rd(8'hC7, v); check("R1 status", v, 0);
    check("R1 osc_en", osc_en, 1);
    check("R1 cpu_clk_en", cpu_clk_en, 1);

    // R2 fields and masks
    wr(8'hC5, 8'hFF); rd(8'hC5, v); check("R2 mode mask", v, 8'h06);
    wr(8'hC5, 8'h00); cyc();
    wr(8'hC6, 8'hFF); rd(8'hC6, v); check("R2 rel_en mask", v, 8'h1E);
    wr(8'hC7, 8'hFF); rd(8'hC7, v); check("R2 status read-only", v, 0);
    rd(8'hC8, v); check("R2 clear reads 0", v, 0);
    wr(8'h40, 8'hFF); rd(8'h40, v); check("R2 unmapped", v, 0);
    rd(8'hC5, v); check("R2 unmapped write no effect", v, 0);

    // R9 events outside low power do not set status
    evt_drv = 4'hF; cyc(); evt_drv = '0;
    rd(8'hC7, v); check("R9 no status in normal", v, 0);

    // Halt sweep: R3 R5 R6 R9
    for (int src = 0; src < 4; src++) begin
      for (int mask = 0; mask < 16; mask++) begin
        logic rel;
        rel = mask[src];
        wr(8'hC6, 8'(mask << 1));
        wr(8'hC8, 8'hFF);
        wr(8'hC5, 8'h02);
        check("R3 cpu_clk_en lags halt write", cpu_clk_en, 1);
        cyc();
        check("R3 cpu_clk_en off in halt", cpu_clk_en, 0);
        check("R3 osc_en on in halt", osc_en, 1);
        evt_drv[src] = 1'b1; cyc(); evt_drv = '0;
        rd(8'hC5, v);
        check(rel ? "R5 halt released" : "R6 halt held", v, rel ? 0 : 2);
        rd(8'hC7, v);
        check("R9 status cause", v, rel ? (1 << (src + 1)) : 0);
        cyc();
        check(rel ? "R5 cpu_clk_en returns" : "R6 cpu_clk_en stays off", cpu_clk_en, rel ? 1 : 0);
        if (!rel) begin wr(8'hC5, 8'h00); cyc(); end
      end
    end

    // Stop sweep: R4 R7 R8 R9
    for (int src = 0; src < 4; src++) begin
      wr(8'hC6, 8'h00);
      wr(8'hC8, 8'hFF);
      wr(8'hC5, 8'h04);
      check("R4 osc_en drops with stop", osc_en, 0);
      cyc();
      check("R4 cpu_clk_en off in stop", cpu_clk_en, 0);
      evt_drv[src] = 1'b1; cyc(); evt_drv = '0;
      rd(8'hC5, v);
      check(src == 1 ? "R7 port wakes stop" : "R8 timer ignored in stop", v, src == 1 ? 0 : 4);
      check(src == 1 ? "R7 osc_en back" : "R8 osc_en still off", osc_en, src == 1 ? 1 : 0);
      rd(8'hC7, v); check("R9 no status from stop", v, 0);
      wr(8'hC5, 8'h00); cyc();
    end

    // R7 both bits set, port clears both
    wr(8'hC5, 8'h06);
    evt_drv[1] = 1'b1; cyc(); evt_drv = '0;
    rd(8'hC5, v); check("R7 both bits cleared", v, 0);
    cyc();

    // R9 simultaneous enabled events
    wr(8'hC6, 8'h0A); wr(8'hC8, 8'hFF); wr(8'hC5, 8'h02);
    evt_drv = 4'hF; cyc(); evt_drv = '0;
    rd(8'hC7, v); check("R9 multiple causes", v, 8'h0A);

    // R10 per-bit clear
    wr(8'hC8, 8'h02); rd(8'hC7, v); check("R10 per-bit clear", v, 8'h08);

    // R10 set wins over clear in same cycle
    wr(8'hC6, 8'h02); wr(8'hC5, 8'h02);
    bus_addr = 8'hC8; bus_wdata = 8'h0A; bus_we = 1'b1; evt_drv[0] = 1'b1;
    cyc();
    bus_we = 1'b0; evt_drv = '0;
    rd(8'hC7, v); check("R10 set beats clear", v, 8'h02);

    // R11 wake beats mode write in halt
    wr(8'hC5, 8'h02);
    bus_addr = 8'hC5; bus_wdata = 8'h02; bus_we = 1'b1; evt_drv[0] = 1'b1;
    cyc();
    bus_we = 1'b0; evt_drv = '0;
    rd(8'hC5, v); check("R11 halt wake beats write", v, 0);

    // R11 wake beats mode write in stop
    wr(8'hC5, 8'h04);
    bus_addr = 8'hC5; bus_wdata = 8'h04; bus_we = 1'b1; evt_drv[1] = 1'b1;
    cyc();
    bus_we = 1'b0; evt_drv = '0;
    rd(8'hC5, v); check("R11 stop wake beats write", v, 0);

    // R12 reset exits low power
    wr(8'hC6, 8'h1E); wr(8'hC5, 8'h06); cyc();
    check("R12 precondition osc off", osc_en, 0);
    rst_n = 1'b0; #0.5;
    check("R12 osc_en async", osc_en, 1);
    check("R12 cpu_clk_en async", cpu_clk_en, 1);
    cyc(); rst_n = 1'b1; repeat (4) cyc();
    rd(8'hC5, v); check("R12 mode cleared", v, 0);
    rd(8'hC6, v); check("R12 rel_en cleared", v, 0);
    rd(8'hC7, v); check("R12 status cleared", v, 0);

    summary();
  end
endmodule